// File: doc/BRIEF.md
# Low-Power Escape Receiver

This block watches the two single-ended wires of one serial lane while the lane sits in its low-power signalling regime. The wire pair is sampled by a system clock that runs much faster than the line, so every wire state spans many samples. A deglitch stage accepts a new two-wire state only after it has held for a set number of samples. A sequence state machine runs on the accepted states. It recognises the five-state pattern that opens an escape, recovers bits from the spaced one-hot marks that follow, and recognises the two-state pattern that closes the escape. The recovered bit clock is the XOR of the two wires: a mark (exactly one wire high) is a clock high phase, and a space (both low) is the low phase.

A wire state is written LP-pn, with p the positive wire and n the negative wire. The state machine has these states: STOP (idle, line at LP-11), ENT_A (LP-10 seen), ENT_B (first LP-00 seen), ENT_C (LP-01 seen), SPACE (in escape, both wires low), MARK_ONE (in escape, positive wire high) and MARK_ZERO (in escape, negative wire high). Its transitions are:
- STOP→ENT_A on LP-10, then ENT_A→ENT_B on LP-00, ENT_B→ENT_C on LP-01, and ENT_C→SPACE on LP-00.
- SPACE→MARK_ONE on LP-10 and SPACE→MARK_ZERO on LP-01.
- MARK_ONE→SPACE and MARK_ZERO→SPACE on LP-00. Each of these commits a bit.
- MARK_ONE→STOP on LP-11. This is the exit.
- Any other accepted state seen from ENT_A, ENT_B, ENT_C, SPACE, MARK_ONE or MARK_ZERO is an error and leads to STOP.

Received bytes are delivered with a one-cycle strobe. Byte delivery is the whole job: what a received command means is left to the logic downstream.

Top module: `esc_lp_rx`

## Requirements
- R1: After reset, `esc_active`, `rx_valid` and `seq_err` are all 0, and the accepted line state is LP-11.
- R2: `esc_active` rises only after the accepted states LP-11, LP-10, LP-00, LP-01, LP-00 have occurred in that order. It stays at 1 while the escape lasts.
- R3: During entry, an accepted state that breaks the order pulses `seq_err` for one cycle and returns the machine to STOP. A fresh entry must then start again from LP-10, so the rest of a broken pattern does not enter escape.
- R4: In STOP, every accepted state other than LP-10 is ignored: no error pulse and no escape.
- R5: A bit is captured when the recovered clock rises, that is, when the line leaves a space. LP-10 gives 1 and LP-01 gives 0. The bit is committed when the line returns to LP-00.
- R6: Bits are packed least significant first. After every eighth committed bit, `rx_valid` is 1 for exactly one cycle with the byte on `rx_byte`.
- R7: While in escape, LP-10 followed by LP-11 ends the escape and clears `esc_active`. The closing LP-10 is not taken as a data bit.
- R8: An exit that comes after a non-zero number of bits since the last whole byte pulses `seq_err`. Those bits are discarded, so the next escape starts its first byte empty.
- R9: A line state held for fewer than STABLE_CYC consecutive samples is never accepted and has no effect.
- R10: Inside escape, an illegal step pulses `seq_err` and ends the escape. The illegal steps are a mark moving straight to the other mark, a mark moving to LP-11 other than the MARK_ONE exit, and a space moving to LP-11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_p | input | 1 | Synchronized level of the positive wire |
| lp_n | input | 1 | Synchronized level of the negative wire |
| esc_active | output | 1 | High while an escape is in progress |
| rx_byte | output | BYTE_W | Last assembled byte, least significant bit received first |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_byte` |
| seq_err | output | 1 | One-cycle pulse on an illegal sequence or a partial-byte exit |

## Verification
The bench builds the block with STABLE_CYC = 4 and BYTE_W = 8. It holds each intended wire state for 8 samples, which is well above the acceptance threshold. Glitches last 2 samples, which is below it. With the threshold this small, short glitches can be placed next to real states, inside both entry and escape, and checked for no effect while full bytes remain short runs. The byte values 0x01, 0xA5 and 0x3C are used because they expose a bit order or shift offset that is wrong.

// File: rtl/esc_lp_pkg.sv
package esc_lp_pkg;

    // Two-wire line state, bit 1 = positive wire, bit 0 = negative wire
    typedef enum logic [1:0] {
        LN_00 = 2'b00,
        LN_01 = 2'b01,
        LN_10 = 2'b10,
        LN_11 = 2'b11
    } line_t;

    typedef enum logic [2:0] {
        ST_STOP      = 3'd0,
        ST_ENT_A     = 3'd1,
        ST_ENT_B     = 3'd2,
        ST_ENT_C     = 3'd3,
        ST_SPACE     = 3'd4,
        ST_MARK_ONE  = 3'd5,
        ST_MARK_ZERO = 3'd6
    } seq_st_t;

endpackage

// File: rtl/esc_lp_deglitch.sv
module esc_lp_deglitch
    import esc_lp_pkg::*;
#(
    parameter int STABLE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] raw,
    output line_t      line,
    output logic       line_chg
);
    localparam int CW = $clog2(STABLE_CYC + 1);

    logic [1:0]    cand;
    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand     <= 2'b11;
            run      <= CW'(STABLE_CYC);
            line     <= LN_11;
            line_chg <= 1'b0;
        end else begin
            line_chg <= 1'b0;
            if (raw != cand) begin
                cand <= raw;
                run  <= CW'(1);
            end else begin
                if (run < CW'(STABLE_CYC))
                    run <= run + 1'b1;
                // this sample completes a run of STABLE_CYC equal samples
                if (run == CW'(STABLE_CYC - 1) && line_t'(cand) != line) begin
                    line     <= line_t'(cand);
                    line_chg <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/esc_lp_seq_fsm.sv
module esc_lp_seq_fsm
    import esc_lp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  line_t   line,
    input  logic    line_chg,
    input  logic    partial,
    output logic    esc_active,
    output logic    bit_vld,
    output logic    bit_val,
    output logic    asm_clr,
    output logic    seq_err,
    output seq_st_t state_o
);
    seq_st_t state, nxt;
    logic    go_n, val_n, clr_n, err_n;

    always_comb begin
        nxt   = state;
        go_n  = 1'b0;
        val_n = 1'b0;
        clr_n = 1'b0;
        err_n = 1'b0;
        if (line_chg) begin
            unique case (state)
                ST_STOP: begin
                    if (line == LN_10) nxt = ST_ENT_A;
                end
                ST_ENT_A: begin
                    if (line == LN_00) nxt = ST_ENT_B;
                    else begin nxt = ST_STOP; err_n = 1'b1; end
                end
                ST_ENT_B: begin
                    if (line == LN_01) nxt = ST_ENT_C;
                    else begin nxt = ST_STOP; err_n = 1'b1; end
                end
                ST_ENT_C: begin
                    if (line == LN_00) begin nxt = ST_SPACE; clr_n = 1'b1; end
                    else begin nxt = ST_STOP; err_n = 1'b1; end
                end
                ST_SPACE: begin
                    if (line == LN_10)      nxt = ST_MARK_ONE;
                    else if (line == LN_01) nxt = ST_MARK_ZERO;
                    else begin nxt = ST_STOP; err_n = 1'b1; clr_n = 1'b1; end
                end
                ST_MARK_ONE: begin
                    if (line == LN_00) begin
                        nxt = ST_SPACE; go_n = 1'b1; val_n = 1'b1;
                    end else if (line == LN_11) begin
                        nxt = ST_STOP; clr_n = 1'b1; err_n = partial;
                    end else begin
                        nxt = ST_STOP; err_n = 1'b1; clr_n = 1'b1;
                    end
                end
                ST_MARK_ZERO: begin
                    if (line == LN_00) begin
                        nxt = ST_SPACE; go_n = 1'b1;
                    end else begin
                        nxt = ST_STOP; err_n = 1'b1; clr_n = 1'b1;
                    end
                end
                default: nxt = ST_STOP;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_STOP;
        else        state <= nxt;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            esc_active <= 1'b0;
            bit_vld    <= 1'b0;
            bit_val    <= 1'b0;
            asm_clr    <= 1'b0;
            seq_err    <= 1'b0;
        end else begin
            esc_active <= (nxt == ST_SPACE) || (nxt == ST_MARK_ONE) || (nxt == ST_MARK_ZERO);
            bit_vld    <= go_n;
            bit_val    <= val_n;
            asm_clr    <= clr_n;
            seq_err    <= err_n;
        end
    end

    assign state_o = state;
endmodule

// File: rtl/esc_lp_byte_asm.sv
module esc_lp_byte_asm #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              bit_val,
    input  logic              clr,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              partial
);
    localparam int NW = $clog2(BYTE_W);

    logic [BYTE_W-1:0] shreg;
    logic [NW-1:0]     nbits;
    logic [BYTE_W-1:0] shifted;

    assign shifted = {bit_val, shreg[BYTE_W-1:1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            nbits    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (clr) begin
                nbits <= '0;
            end else if (bit_vld) begin
                shreg <= shifted;
                if (nbits == NW'(BYTE_W - 1)) begin
                    nbits    <= '0;
                    rx_byte  <= shifted;
                    rx_valid <= 1'b1;
                end else begin
                    nbits <= nbits + 1'b1;
                end
            end
        end
    end

    assign partial = (nbits != '0);
endmodule

// File: rtl/esc_lp_rx.sv
module esc_lp_rx
    import esc_lp_pkg::*;
#(
    parameter int STABLE_CYC = 4,
    parameter int BYTE_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lp_p,
    input  logic              lp_n,
    output logic              esc_active,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              seq_err
);
    line_t   line;
    logic    line_chg;
    logic    partial, bit_vld, bit_val, asm_clr;
    seq_st_t fsm_state;

    esc_lp_deglitch #(.STABLE_CYC(STABLE_CYC)) u_dg (
        .clk(clk), .rst_n(rst_n), .raw({lp_p, lp_n}),
        .line(line), .line_chg(line_chg)
    );

    esc_lp_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .line(line), .line_chg(line_chg),
        .partial(partial), .esc_active(esc_active), .bit_vld(bit_vld),
        .bit_val(bit_val), .asm_clr(asm_clr), .seq_err(seq_err),
        .state_o(fsm_state)
    );

    esc_lp_byte_asm #(.BYTE_W(BYTE_W)) u_asm (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
        .clr(asm_clr), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .partial(partial)
    );
endmodule

// File: rtl/esc_lp_rx_chk.sv
module esc_lp_rx_chk
    import esc_lp_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    esc_active,
    input logic    rx_valid,
    input logic    seq_err,
    input seq_st_t fsm_state
);
    // R6: byte strobe lasts one cycle
    p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R6: bytes are only delivered inside an escape
    p_byte_in_esc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> esc_active);

    // R2: escape starts only out of the last entry step
    p_entry_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(esc_active) |-> $past(fsm_state) == ST_ENT_C);

    // R3 / R10: an error always leaves the block idle
    p_err_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> (!esc_active && fsm_state == ST_STOP));

    // R4: nothing seen in STOP raises an error
    p_stop_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fsm_state) == ST_STOP) |-> !seq_err);

    // R6 / R8: error and byte strobe never coincide
    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_valid, seq_err}));
endmodule

bind esc_lp_rx esc_lp_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .esc_active(esc_active),
    .rx_valid(rx_valid), .seq_err(seq_err), .fsm_state(fsm_state)
);

// File: tb/test_esc_lp_rx.sv
`timescale 1ns/1ps
module test_esc_lp_rx;
    localparam int HOLD = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lp_p = 1'b1, lp_n = 1'b1;
    logic       esc_active, rx_valid, seq_err;
    logic [7:0] rx_byte;

    int checks = 0, errors = 0;
    int nbytes = 0, nerr = 0;
    logic [7:0] last_byte = 8'h00;
    bit done = 1'b0;

    always #10 clk = ~clk;

    esc_lp_rx #(.STABLE_CYC(4), .BYTE_W(8)) i_esc_lp_rx (
        .clk(clk), .rst_n(rst_n), .lp_p(lp_p), .lp_n(lp_n),
        .esc_active(esc_active), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .seq_err(seq_err)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin nbytes++; last_byte = rx_byte; end
            if (seq_err) nerr++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic p, input logic n, input int cyc);
        @(negedge clk);
        lp_p = p; lp_n = n;
        repeat (cyc) @(negedge clk);
    endtask

    task automatic enter_esc();
        drive(1, 1, HOLD); drive(1, 0, HOLD); drive(0, 0, HOLD);
        drive(0, 1, HOLD); drive(0, 0, HOLD);
    endtask

    task automatic send_bits(input logic [7:0] b, input int cnt);
        for (int i = 0; i < cnt; i++) begin
            if (b[i]) drive(1, 0, HOLD); else drive(0, 1, HOLD);
            drive(0, 0, HOLD);
        end
    endtask

    task automatic exit_esc();
        drive(1, 0, HOLD); drive(1, 1, HOLD);
    endtask

    task automatic t_reset();
        chk("R1 esc_active", esc_active, 0);
        chk("R1 rx_valid", rx_valid, 0);
        chk("R1 seq_err", seq_err, 0);
        chk("R1 no events", nbytes + nerr, 0);
    endtask

    task automatic t_entry_bytes();
        int e0 = nerr;
        enter_esc();
        chk("R2 escape entered", esc_active, 1);
        send_bits(8'h01, 8);
        chk("R6 one byte", nbytes, 1);
        chk("R5 R6 lsb first 0x01", last_byte, 8'h01);
        send_bits(8'hA5, 8);
        chk("R5 byte 0xA5", last_byte, 8'hA5);
        send_bits(8'h3C, 8);
        chk("R6 byte count", nbytes, 3);
        chk("R6 byte 0x3C", last_byte, 8'h3C);
        chk("R2 still active", esc_active, 1);
        exit_esc();
        chk("R7 exit clears", esc_active, 0);
        chk("R7 no extra byte", nbytes, 3);
        chk("R7 clean exit no error", nerr, e0);
    endtask

    task automatic t_partial();
        int e0 = nerr, b0 = nbytes;
        enter_esc();
        send_bits(8'h07, 3);
        exit_esc();
        chk("R8 partial exit error", nerr, e0 + 1);
        chk("R8 no byte", nbytes, b0);
        enter_esc();
        send_bits(8'hC3, 8);
        chk("R8 fresh byte", last_byte, 8'hC3);
        exit_esc();
        chk("R8 no error on whole byte", nerr, e0 + 1);
    endtask

    task automatic t_entry_bad();
        int e0 = nerr;
        drive(1, 1, HOLD); drive(1, 0, HOLD); drive(0, 0, HOLD);
        drive(1, 0, HOLD);
        chk("R3 order error", nerr, e0 + 1);
        drive(0, 0, HOLD); drive(0, 1, HOLD); drive(0, 0, HOLD);
        chk("R3 no escape from tail", esc_active, 0);
        chk("R3 single pulse", nerr, e0 + 1);
        drive(1, 1, HOLD);
    endtask

    task automatic t_stop_ignore();
        int e0 = nerr;
        drive(0, 1, HOLD); drive(0, 0, HOLD); drive(0, 1, HOLD);
        drive(1, 1, HOLD);
        chk("R4 no error in stop", nerr, e0);
        chk("R4 no escape", esc_active, 0);
    endtask

    task automatic t_glitch();
        int e0 = nerr;
        drive(1, 0, 2); drive(1, 1, HOLD);
        chk("R9 stop glitch ignored", nerr, e0);
        drive(1, 0, HOLD); drive(0, 0, HOLD); drive(1, 1, 2); drive(0, 0, HOLD);
        drive(0, 1, HOLD); drive(0, 0, HOLD);
        chk("R9 entry glitch ignored", esc_active, 1);
        drive(1, 0, 2); drive(0, 0, HOLD);
        send_bits(8'h5A, 8);
        chk("R9 no spurious bit", last_byte, 8'h5A);
        chk("R9 no error", nerr, e0);
        exit_esc();
    endtask

    task automatic t_illegal_esc();
        int e0 = nerr;
        enter_esc();
        drive(0, 1, HOLD); drive(1, 0, HOLD);
        chk("R10 mark to mark error", nerr, e0 + 1);
        chk("R10 escape left", esc_active, 0);
        drive(1, 1, HOLD);
        enter_esc();
        drive(1, 1, HOLD);
        chk("R10 space to stop error", nerr, e0 + 2);
        chk("R10 escape left again", esc_active, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_entry_bytes();
        t_partial();
        t_entry_bad();
        t_stop_ignore();
        t_glitch();
        t_illegal_esc();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule